// File: doc/BRIEF.md
# Transfer Byte Counter with Masked Status Interrupt

This block tracks how much of a host-programmed transfer is still outstanding. Software loads a 24-bit remaining-byte count through a narrow register port. Every pulse on `byteDone` means one byte has been fully delivered. Each pulse lowers the count by one and raises a 32-bit position counter by one in the same cycle. The position counter starts at zero after reset and software can only read it.

Surrounding logic reports other transfer events (selection progress, PIO readiness, DMA completion) as one-cycle pulses on `evtSet`. The block holds these events as sticky status bits. It also derives a count-zero flag and a counter-wrap flag. A read of the status offset returns the flags. A write to the same offset clears each flag whose data bit is 1. An enable register picks which flags drive the single `irq` output.

Register offsets (8-bit data): count bytes at 0x0 to 0x2 (least significant byte at 0x0), position bytes at 0x4 to 0x7 (least significant byte at 0x4), status/clear at 0x8, enable at 0x9. Every other offset reads zero. Status bits: 6 selection finished, 5 selected by another device, 4 selection ongoing, 3 counter wrapped, 2 count is zero, 1 PIO ready, 0 DMA finished. Bit 7 always reads 0.

Top module: `xfer_count_irq`

## Requirements
- R1: After reset the count and position read 0, the sticky status bits and the enable bits read 0, status reads 0x04 (count zero), and `irq` is low.
- R2: The count bytes at offsets 0x0, 0x1 and 0x2 can be written and read back, with the least significant byte at 0x0. A write changes only the addressed byte.
- R3: Each cycle with `byteDone` high and no count write lowers the count by exactly one. Without `byteDone` the count changes only through host writes.
- R4: A `byteDone` while the count is 0 makes the count 0xFFFFFF and sets status bit 3.
- R5: The position counter at offsets 0x4 to 0x7 (least significant byte at 0x4) rises by one on every `byteDone`, holds otherwise, and ignores host writes.
- R6: Status bit 2 reads 1 exactly when the count is zero, and a clear write does not change it.
- R7: An `evtSet` pulse sets status bits 6, 5, 4, 1 and 0 at the matching positions. `evtSet` bits 3 and 2 have no effect.
- R8: A write to offset 0x8 clears every sticky status bit whose write data bit is 1 and leaves the others unchanged.
- R9: When a set pulse (from `evtSet` or a wrap) and a clear write hit the same bit in the same cycle, the bit ends set.
- R10: The enable register at offset 0x9 is read/write in bits 6:0, and bit 7 reads 0. `irq` is high exactly when status AND enable is nonzero, starting the cycle after the change.
- R11: A count write in the same cycle as `byteDone` takes effect without any decrement or wrap, while the position counter still advances.
- R12: Offsets 0x3 and 0xA to 0xF read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from `addr` |
| byteDone | input | 1 | One pulse per byte fully transferred |
| evtSet | input | 7 | Status set pulses, aligned with status bit positions |
| irq | output | 1 | Interrupt: any enabled status bit set |

## Verification
A reference model in the bench is checked against every register offset and `irq` after each cycle. Directed sequences cover count zero, the wrap below zero, set-versus-clear collisions and count writes that coincide with `byteDone`; these separate the decrement priority, wrap detection and sticky-bit behaviour. Seeded random traffic mixes writes to any offset (unmapped ones included), byte pulses and event pulses, which exposes lane decoding and mask errors that the directed cases do not reach.

// File: rtl/xfer_count_pkg.sv
package xfer_count_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CNT_W   = 24;
  localparam int POS_W   = 32;
  localparam int STAT_W  = 7;
  localparam int CNT_BYTES = CNT_W / DATA_W;
  localparam int POS_BYTES = POS_W / DATA_W;

  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_POS  = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_EN   = 4'h9;

  localparam int B_WRAP = 3;
  localparam int B_ZERO = 2;

  // bits that external pulses may set, and bits that are held in flops
  localparam logic [STAT_W-1:0] EXT_SET_MASK = 7'h73;
  localparam logic [STAT_W-1:0] STICKY_MASK  = 7'h7B;

  typedef struct packed {
    logic [CNT_BYTES-1:0] cntWr;
    logic                 step;
    logic                 statClr;
    logic                 enWr;
    logic [DATA_W-1:0]    data;
  } strobe_t;
endpackage

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl
  import xfer_count_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              byteDone,
  input  logic [CNT_W-1:0]  cntQ,
  input  logic [POS_W-1:0]  posQ,
  input  logic [STAT_W-1:0] statVal,
  input  logic [STAT_W-1:0] enQ,
  output strobe_t           strb,
  output logic [DATA_W-1:0] rdData
);
  logic [CNT_BYTES-1:0] cntHit;
  logic [POS_BYTES-1:0] posHit;

  genvar g;
  generate
    for (g = 0; g < CNT_BYTES; g++) begin : g_cnt
      assign cntHit[g] = (addr == OFS_CNT + ADDR_W'(g));
    end
    for (g = 0; g < POS_BYTES; g++) begin : g_pos
      assign posHit[g] = (addr == OFS_POS + ADDR_W'(g));
    end
  endgenerate

  always_comb begin
    strb.cntWr   = wrEn ? cntHit : '0;
    strb.step    = byteDone;
    strb.statClr = wrEn && (addr == OFS_STAT);
    strb.enWr    = wrEn && (addr == OFS_EN);
    strb.data    = wrData;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < CNT_BYTES; i++)
      if (cntHit[i]) rdData = cntQ[i*DATA_W +: DATA_W];
    for (int i = 0; i < POS_BYTES; i++)
      if (posHit[i]) rdData = posQ[i*DATA_W +: DATA_W];
    if (addr == OFS_STAT) rdData = {1'b0, statVal};
    if (addr == OFS_EN)   rdData = {1'b0, enQ};
  end
endmodule

// File: rtl/xfer_count_dp.sv
module xfer_count_dp
  import xfer_count_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [STAT_W-1:0] evtSet,
  output logic [CNT_W-1:0]  cntQ,
  output logic [POS_W-1:0]  posQ,
  output logic [STAT_W-1:0] statVal,
  output logic [STAT_W-1:0] enQ,
  output logic              irq
);
  logic [STAT_W-1:0] stickyQ;
  logic [STAT_W-1:0] setVec;
  logic [STAT_W-1:0] clrVec;
  logic              anyCntWr;
  logic              wrapEv;

  assign anyCntWr = |strb.cntWr;
  assign wrapEv   = strb.step && !anyCntWr && (cntQ == '0);
  assign setVec   = (evtSet & EXT_SET_MASK) | (STAT_W'(wrapEv) << B_WRAP);
  assign clrVec   = strb.statClr ? strb.data[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (anyCntWr) begin
      for (int i = 0; i < CNT_BYTES; i++)
        if (strb.cntWr[i]) cntQ[i*DATA_W +: DATA_W] <= strb.data;
    end else if (strb.step) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          posQ <= '0;
    else if (strb.step) posQ <= posQ + POS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) stickyQ <= '0;
    else       stickyQ <= ((stickyQ & ~clrVec) | setVec) & STICKY_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= strb.data[STAT_W-1:0];
  end

  assign statVal = stickyQ | (STAT_W'(cntQ == '0) << B_ZERO);
  assign irq     = |(statVal & enQ);
endmodule

// File: rtl/xfer_count_irq.sv
module xfer_count_irq
  import xfer_count_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              byteDone,
  input  logic [STAT_W-1:0] evtSet,
  output logic              irq
);
  strobe_t           strb;
  logic [CNT_W-1:0]  cntQ;
  logic [POS_W-1:0]  posQ;
  logic [STAT_W-1:0] statVal;
  logic [STAT_W-1:0] enQ;

  xfer_count_ctrl i_ctrl (
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .byteDone(byteDone),
    .cntQ(cntQ), .posQ(posQ), .statVal(statVal), .enQ(enQ),
    .strb(strb), .rdData(rdData)
  );

  xfer_count_dp i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtSet(evtSet),
    .cntQ(cntQ), .posQ(posQ), .statVal(statVal), .enQ(enQ), .irq(irq)
  );
endmodule

// File: rtl/xfer_count_chk.sv
module xfer_count_chk
  import xfer_count_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              byteDone,
  input logic [STAT_W-1:0] evtSet,
  input logic              irq,
  input logic [CNT_W-1:0]  cntQ,
  input logic [POS_W-1:0]  posQ,
  input logic [STAT_W-1:0] statVal,
  input logic [STAT_W-1:0] enQ
);
  logic cntWrNow;
  assign cntWrNow = wrEn && (addr < OFS_CNT + ADDR_W'(CNT_BYTES));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && !cntWrNow |=> cntQ == $past(cntQ) - CNT_W'(1));

  // R5
  pos_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |=> posQ == $past(posQ) + POS_W'(1));

  // R5
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteDone |=> $stable(posQ));

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteDone && !cntWrNow && cntQ == '0 |=> statVal[B_WRAP] && cntQ == '1);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[0] && wrEn && addr == OFS_STAT && wrData[0] |=> statVal[0]);

  // R8
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && addr == OFS_STAT && wrData[1] && !evtSet[1] |=> !statVal[1]);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[0] && enQ[0] && !(wrEn && addr == OFS_EN) |=> irq);
endmodule

bind xfer_count_irq xfer_count_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .byteDone(byteDone), .evtSet(evtSet), .irq(irq),
  .cntQ(cntQ), .posQ(posQ), .statVal(statVal), .enQ(enQ)
);

// File: tb/test_xfer_count_irq.sv
`timescale 1ns/100ps
module test_xfer_count_irq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       byteDone = 1'b0;
  logic [6:0] evtSet = '0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [23:0] mCnt;
  logic [31:0] mPos;
  logic [6:0]  mSticky;
  logic [6:0]  mEn;

  always #10 clk = ~clk;

  xfer_count_irq i_xfer_count_irq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .byteDone(byteDone), .evtSet(evtSet), .irq(irq)
  );

  function automatic logic [6:0] expStat();
    return mSticky | ((mCnt == 24'd0) ? 7'h04 : 7'h00);
  endfunction

  function automatic logic [7:0] expRead(input logic [3:0] a);
    case (a)
      4'h0: return mCnt[7:0];
      4'h1: return mCnt[15:8];
      4'h2: return mCnt[23:16];
      4'h4: return mPos[7:0];
      4'h5: return mPos[15:8];
      4'h6: return mPos[23:16];
      4'h7: return mPos[31:24];
      4'h8: return {1'b0, expStat()};
      4'h9: return {1'b0, mEn};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] a);
    if (a <= 4'h2) return "R2";
    if (a >= 4'h4 && a <= 4'h7) return "R5";
    if (a == 4'h8) return "R7";
    if (a == 4'h9) return "R10";
    return "R12";
  endfunction

  task automatic modelReset();
    mCnt = '0; mPos = '0; mSticky = '0; mEn = '0;
  endtask

  task automatic modelStep(input bit w, input logic [3:0] a, input logic [7:0] d,
                           input bit bd, input logic [6:0] s);
    bit cw;
    bit wrapEv;
    logic [6:0] clr;
    logic [6:0] st;
    cw = w && (a <= 4'h2);
    wrapEv = bd && !cw && (mCnt == 24'd0);
    clr = (w && a == 4'h8) ? d[6:0] : 7'h00;
    st = (s & 7'h73) | (wrapEv ? 7'h08 : 7'h00);
    mSticky = ((mSticky & ~clr) | st) & 7'h7B;
    if (w && a == 4'h9) mEn = d[6:0];
    if (bd) mPos = mPos + 32'd1;
    if (cw) mCnt[a*8 +: 8] = d;
    else if (bd) mCnt = mCnt - 24'd1;
  endtask

  // called just after a falling edge; applies stimulus over one rising edge
  task automatic cycle(input bit w, input logic [3:0] a, input logic [7:0] d,
                       input bit bd, input logic [6:0] s);
    wrEn = w; addr = a; wrData = d; byteDone = bd; evtSet = s;
    @(posedge clk);
    modelStep(w, a, d, bd, s);
    @(negedge clk);
    wrEn = 1'b0; byteDone = 1'b0; evtSet = '0;
  endtask

  task automatic checkAll(input string tag);
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #0.5;
      total++;
      if (rdData !== expRead(4'(a))) begin
        bad++;
        $display("FAIL %s %s addr=%0h actual=%02h expected=%02h",
                 tag, reqOf(4'(a)), a, rdData, expRead(4'(a)));
      end
    end
    total++;
    if (irq !== |(expStat() & mEn)) begin
      bad++;
      $display("FAIL %s R10 irq actual=%0b expected=%0b", tag, irq, |(expStat() & mEn));
    end
  endtask

  initial begin
    #(20.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkAll("R1 reset");

    // R2 byte lanes, little-endian
    cycle(1, 4'h0, 8'h02, 0, '0);
    cycle(1, 4'h1, 8'h01, 0, '0);
    checkAll("R2 load");
    // R3 decrement, R5 position advance
    cycle(0, 4'h0, 8'h00, 1, '0);
    checkAll("R3 step");
    // R5 writes to position ignored
    cycle(1, 4'h4, 8'h55, 0, '0);
    cycle(1, 4'h7, 8'hAA, 0, '0);
    checkAll("R5 ro");
    // R6 count zero flag with enable
    cycle(1, 4'h1, 8'h00, 0, '0);
    cycle(1, 4'h0, 8'h01, 0, '0);
    cycle(1, 4'h9, 8'h04, 0, '0);
    checkAll("R6 pre");
    cycle(0, 4'h0, 8'h00, 1, '0);
    checkAll("R6 zero");
    cycle(1, 4'h8, 8'h04, 0, '0);
    checkAll("R6 noclr");
    // R4 wrap below zero
    cycle(0, 4'h0, 8'h00, 1, '0);
    checkAll("R4 wrap");
    // R8 clear all, R7 ignored event bits
    cycle(1, 4'h8, 8'h7F, 0, '0);
    checkAll("R8 clrall");
    cycle(0, 4'h0, 8'h00, 0, 7'h0C);
    checkAll("R7 ignored");
    cycle(0, 4'h0, 8'h00, 0, 7'h73);
    checkAll("R7 set");
    cycle(1, 4'h8, 8'h21, 0, '0);
    checkAll("R8 partial");
    // R9 set wins against clear
    cycle(1, 4'h8, 8'h01, 0, 7'h01);
    checkAll("R9 collide");
    // R10 enable masks
    cycle(1, 4'h9, 8'hFF, 0, '0);
    checkAll("R10 en");
    cycle(1, 4'h8, 8'h7F, 0, '0);
    cycle(1, 4'h9, 8'h00, 0, '0);
    cycle(0, 4'h0, 8'h00, 0, 7'h02);
    checkAll("R10 masked");
    // R11 count write collides with byteDone
    cycle(1, 4'h2, 8'h10, 1, '0);
    checkAll("R11 collide");
    cycle(1, 4'h0, 8'h00, 0, '0);
    cycle(1, 4'h1, 8'h00, 0, '0);
    cycle(1, 4'h2, 8'h00, 1, '0);
    checkAll("R11 nowrap");
    // R12 unmapped writes
    cycle(1, 4'h3, 8'hFF, 0, '0);
    cycle(1, 4'hC, 8'hFF, 0, '0);
    checkAll("R12 unmapped");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] a;
      a = 4'($urandom % 12);
      if (a == 4'h8 && ($urandom % 2) == 0) a = 4'h9;
      cycle(($urandom % 3) == 0, a, 8'($urandom), ($urandom % 2) == 0,
            (($urandom % 4) == 0) ? 7'($urandom) : 7'h00);
      checkAll("RAND");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule